// File: doc/BRIEF.md
# Serial Port Interrupt Status and Mask Aggregator

This block collects every interrupt source of a serial port and turns them into one level-sensitive interrupt line. Five live status levels come in from the receive and transmit paths: trigger level reached, receive queue empty, receive queue full, transmit queue empty and transmit queue full. Five single-cycle event pulses come in from the error and timing logic: overrun, framing error, parity error, receive timeout and modem line change. Each source owns one bit of a sticky status word. A bit stays set until software clears it by writing a one to it, and a live level that is still high keeps its bit set.

A mask word chooses which sticky bits may raise the interrupt. Software changes the mask only through two strobe addresses: one ORs the written ones into the mask and the other clears them. The mask address itself can only be read. Register access uses a plain single-cycle port. A write takes effect at the clock edge on which `wr_en` is high, and read data follows `addr` combinationally. Framing, queue storage and bit timing sit outside this block and reach it only through the status and event inputs.

Top module: `uirq_aggregator`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) clears the mask and the sticky status to zero, so `irq` is low after reset.
- R2: A write to address 0 ORs `wdata` into the mask, and the new mask can be read at address 2 after that edge.
- R3: A write to address 1 clears every mask bit where `wdata` is one and leaves the other mask bits unchanged.
- R4: A write to address 2 leaves the mask unchanged.
- R5: At each clock edge, every bit of `live_stat[4:0]` that is high sets the sticky bit of the same index (bit0 trigger reached, bit1 receive empty, bit2 receive full, bit3 transmit empty, bit4 transmit full). The sticky bit stays set after the level drops.
- R6: A pulse on `evt_pulse[k]` sets sticky bit 5+k at that edge (bit5 overrun, bit6 framing, bit7 parity, bit8 receive timeout, bit9 modem change).
- R7: A write to address 3 clears every sticky bit where `wdata` is one, provided no source sets that bit in the same cycle.
- R8: When an event pulse and a clear write hit the same sticky bit in one cycle, the bit ends up set.
- R9: A sticky bit in 0 to 4 whose live level is still high stays set through a clear write. It clears only once the level is low.
- R10: `irq` is high exactly when some bit is set in both the mask and the sticky status, and it follows register changes without further delay.
- R11: Reads have no side effects. Address 4 returns the live status in bits 4:0 with zeros above, addresses 0 and 1 read as zero, and addresses 5 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 3 | Register word address |
| wdata | input | 10 | Write data |
| rdata | output | 10 | Read data for `addr` |
| live_stat | input | 5 | Live status levels from the receive and transmit paths |
| evt_pulse | input | 5 | Single-cycle error and timing events |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest situation to reach from the ports is a collision: a source setting a sticky bit on the same edge that software clears it. The bench gets there by raising an event pulse and a clear write on the same falling edge, so both are sampled at one rising edge. A second collision holds a live level high across a clear write. Each collision is set up with a bystander bit that is already set and included in the clear. This shows that the clear itself worked while the colliding bit survived.

// File: rtl/uirq_pkg.sv
// Package: shared address map and widths for the interrupt aggregator.
// Assumes word addressing on a 3-bit register port.
package uirq_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_ENA    = 3'd0,
        A_DIS    = 3'd1,
        A_MASK   = 3'd2,
        A_STICKY = 3'd3,
        A_LIVE   = 3'd4
    } reg_addr_e;

endpackage

// File: rtl/uirq_decode.sv
// Module: turns a write on the register port into one-hot strobes.
// Assumes addr is stable while wr_en is high; reads need no decode here.
module uirq_decode
    import uirq_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              ena_wr,
    output logic              dis_wr,
    output logic              clr_wr
);

    // Decode the write strobes; the mask address produces none.
    always_comb begin
        ena_wr = wr_en && (addr == A_ENA);
        dis_wr = wr_en && (addr == A_DIS);
        clr_wr = wr_en && (addr == A_STICKY);
    end

endmodule

// File: rtl/uirq_mask_reg.sv
// Module: interrupt mask, changed only by set and clear strobes.
// Assumes ena_wr and dis_wr are never high together.
module uirq_mask_reg #(
    parameter int STAT_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ena_wr,
    input  logic              dis_wr,
    input  logic [STAT_W-1:0] wdata,
    output logic [STAT_W-1:0] mask_q
);

    logic [STAT_W-1:0] set_v;
    logic [STAT_W-1:0] clr_v;

    // Select the write data as a set or clear vector.
    always_comb begin
        set_v = ena_wr ? wdata : '0;
        clr_v = dis_wr ? wdata : '0;
    end

    // Hold the mask; reset to all-disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= (mask_q | set_v) & ~clr_v;
    end

endmodule

// File: rtl/uirq_sticky_reg.sv
// Module: sticky status word with write-one-to-clear.
// Live levels occupy the low bits and event pulses the high bits.
// A source that is active wins over a clear in the same cycle.
module uirq_sticky_reg #(
    parameter int LIVE_W = 5,
    parameter int EVT_W  = 5,
    localparam int STAT_W = LIVE_W + EVT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_wr,
    input  logic [STAT_W-1:0] wdata,
    input  logic [LIVE_W-1:0] live_stat,
    input  logic [EVT_W-1:0]  evt_pulse,
    output logic [STAT_W-1:0] sticky_q
);

    logic [STAT_W-1:0] src_v;
    logic [STAT_W-1:0] clr_v;

    // Place live levels and event pulses at their bit positions.
    always_comb src_v = {evt_pulse, live_stat};

    // Build the clear vector from a write to the sticky address.
    always_comb clr_v = clr_wr ? wdata : '0;

    // One flop per source: set has priority over clear.
    for (genvar b = 0; b < STAT_W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)        sticky_q[b] <= 1'b0;
            else if (src_v[b]) sticky_q[b] <= 1'b1;
            else if (clr_v[b]) sticky_q[b] <= 1'b0;
        end
    end

endmodule

// File: rtl/uirq_readmux.sv
// Module: combinational read data for the register port.
// Assumes LIVE_W <= STAT_W; unmapped and strobe addresses read zero.
module uirq_readmux
    import uirq_pkg::*;
#(
    parameter int LIVE_W = 5,
    parameter int STAT_W = 10
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [STAT_W-1:0] mask_q,
    input  logic [STAT_W-1:0] sticky_q,
    input  logic [LIVE_W-1:0] live_stat,
    output logic [STAT_W-1:0] rdata
);

    // Pick the register addressed; no state is touched by a read.
    always_comb begin
        case (addr)
            A_MASK:   rdata = mask_q;
            A_STICKY: rdata = sticky_q;
            A_LIVE:   rdata = STAT_W'(live_stat);
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/uirq_aggregator.sv
// Module: top of the serial port interrupt aggregator.
// Contains the write decode, the mask, the sticky status, the read mux
// and the interrupt line. The interrupt is a level that follows the
// register state with no extra flop.
module uirq_aggregator
    import uirq_pkg::*;
#(
    parameter int LIVE_W = 5,
    parameter int EVT_W  = 5,
    localparam int STAT_W = LIVE_W + EVT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [STAT_W-1:0] wdata,
    output logic [STAT_W-1:0] rdata,
    input  logic [LIVE_W-1:0] live_stat,
    input  logic [EVT_W-1:0]  evt_pulse,
    output logic              irq
);

    logic              ena_wr;
    logic              dis_wr;
    logic              clr_wr;
    logic [STAT_W-1:0] mask_q;
    logic [STAT_W-1:0] sticky_q;

    uirq_decode u_decode (
        .wr_en  (wr_en),
        .addr   (addr),
        .ena_wr (ena_wr),
        .dis_wr (dis_wr),
        .clr_wr (clr_wr)
    );

    uirq_mask_reg #(.STAT_W(STAT_W)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .ena_wr (ena_wr),
        .dis_wr (dis_wr),
        .wdata  (wdata),
        .mask_q (mask_q)
    );

    uirq_sticky_reg #(.LIVE_W(LIVE_W), .EVT_W(EVT_W)) u_sticky (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_wr    (clr_wr),
        .wdata     (wdata),
        .live_stat (live_stat),
        .evt_pulse (evt_pulse),
        .sticky_q  (sticky_q)
    );

    uirq_readmux #(.LIVE_W(LIVE_W), .STAT_W(STAT_W)) u_rmux (
        .addr      (addr),
        .mask_q    (mask_q),
        .sticky_q  (sticky_q),
        .live_stat (live_stat),
        .rdata     (rdata)
    );

    // Raise the interrupt while any enabled sticky bit is set.
    always_comb irq = |(mask_q & sticky_q);

endmodule

// File: rtl/uirq_aggregator_chk.sv
// Module: assertion checker for uirq_aggregator, attached by bind.
// Observes the port and the mask and sticky state of the top.
module uirq_aggregator_chk
    import uirq_pkg::*;
#(
    parameter int LIVE_W = 5,
    parameter int EVT_W  = 5,
    localparam int STAT_W = LIVE_W + EVT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [STAT_W-1:0] wdata,
    input logic [LIVE_W-1:0] live_stat,
    input logic [EVT_W-1:0]  evt_pulse,
    input logic [STAT_W-1:0] mask_q,
    input logic [STAT_W-1:0] sticky_q
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (mask_q == '0 && sticky_q == '0));

    // R2
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_ENA) |=> ((mask_q & $past(wdata)) == $past(wdata)));

    // R4
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !(wr_en && (addr == A_ENA || addr == A_DIS))) |=> $stable(mask_q));

    // R5
    live_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_stat != '0) |=> ((sticky_q[LIVE_W-1:0] & $past(live_stat)) == $past(live_stat)));

    // R6
    evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse != '0) |=> ((sticky_q[STAT_W-1:LIVE_W] & $past(evt_pulse)) == $past(evt_pulse)));

    // R7
    wtc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_STICKY) |=>
        ((sticky_q & $past(wdata) & ~$past({evt_pulse, live_stat})) == '0));

endmodule

bind uirq_aggregator uirq_aggregator_chk #(.LIVE_W(LIVE_W), .EVT_W(EVT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .live_stat (live_stat),
    .evt_pulse (evt_pulse),
    .mask_q    (mask_q),
    .sticky_q  (sticky_q)
);

// File: tb/uirq_aggregator_bench.sv
`timescale 1ns/1ps
module uirq_aggregator_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [9:0] wdata = '0;
    logic [9:0] rdata;
    logic [4:0] live_stat = '0;
    logic [4:0] evt_pulse = '0;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    uirq_aggregator u_uirq_aggregator (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .live_stat (live_stat),
        .evt_pulse (evt_pulse),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=0x%03h expected=0x%03h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [9:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [9:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic pulse(input logic [4:0] e);
        @(negedge clk);
        evt_pulse = e;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    task automatic t_reset();
        logic [9:0] v;
        rd(3'd2, v); check("R1 mask", v, 10'h000);
        rd(3'd3, v); check("R1 sticky", v, 10'h000);
        check("R1 irq", {9'b0, irq}, 10'h000);
    endtask

    task automatic t_mask_set_clear();
        logic [9:0] v;
        wr(3'd0, 10'h0A5); rd(3'd2, v); check("R2 first set", v, 10'h0A5);
        wr(3'd0, 10'h300); rd(3'd2, v); check("R2 accumulate", v, 10'h3A5);
        wr(3'd1, 10'h021); rd(3'd2, v); check("R3 clear", v, 10'h384);
    endtask

    task automatic t_mask_ignored();
        logic [9:0] v;
        wr(3'd2, 10'h3FF); rd(3'd2, v); check("R4 direct write", v, 10'h384);
        wr(3'd2, 10'h000); rd(3'd2, v); check("R4 direct zero", v, 10'h384);
        wr(3'd1, 10'h3FF); rd(3'd2, v); check("R3 clear all", v, 10'h000);
    endtask

    task automatic t_live_copy();
        logic [9:0] v;
        @(negedge clk); live_stat = 5'b01001;
        @(negedge clk); live_stat = 5'b00000;
        rd(3'd3, v); check("R5 copy", v, 10'h009);
        @(negedge clk);
        rd(3'd3, v); check("R5 held after drop", v, 10'h009);
        wr(3'd3, 10'h3FF); rd(3'd3, v); check("R7 clear live bits", v, 10'h000);
    endtask

    task automatic t_events();
        logic [9:0] v;
        pulse(5'b10101); rd(3'd3, v); check("R6 events", v, 10'h2A0);
        wr(3'd3, 10'h0A0); rd(3'd3, v); check("R7 partial clear", v, 10'h200);
        wr(3'd3, 10'h200); rd(3'd3, v); check("R7 final clear", v, 10'h000);
    endtask

    task automatic t_set_wins();
        logic [9:0] v;
        pulse(5'b00100);
        @(negedge clk);
        wr_en = 1'b1; addr = 3'd3; wdata = 10'h0C0; evt_pulse = 5'b00010;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0; evt_pulse = '0;
        rd(3'd3, v); check("R8 set beats clear", v, 10'h040);
        wr(3'd3, 10'h040); rd(3'd3, v); check("R7 after collision", v, 10'h000);
    endtask

    task automatic t_live_reassert();
        logic [9:0] v;
        pulse(5'b01000);
        @(negedge clk); live_stat = 5'b00100;
        wr(3'd3, 10'h104); rd(3'd3, v); check("R9 held by level", v, 10'h004);
        live_stat = 5'b00000;
        wr(3'd3, 10'h004); rd(3'd3, v); check("R9 clears after level drops", v, 10'h000);
    endtask

    task automatic t_irq();
        logic [9:0] v;
        pulse(5'b01000);
        check("R10 masked source", {9'b0, irq}, 10'h000);
        wr(3'd0, 10'h100); #1; check("R10 enabled source", {9'b0, irq}, 10'h001);
        wr(3'd1, 10'h100); #1; check("R10 disabled again", {9'b0, irq}, 10'h000);
        wr(3'd0, 10'h100);
        wr(3'd3, 10'h100); #1; check("R10 cleared source", {9'b0, irq}, 10'h000);
        rd(3'd2, v); check("R10 mask kept", v, 10'h100);
        wr(3'd1, 10'h3FF);
    endtask

    task automatic t_read_map();
        logic [9:0] v;
        @(negedge clk); live_stat = 5'b11111;
        rd(3'd4, v); check("R11 live read", v, 10'h01F);
        live_stat = 5'b00000;
        @(negedge clk);
        wr(3'd3, 10'h3FF);
        pulse(5'b00001);
        rd(3'd0, v); check("R11 enable address", v, 10'h000);
        rd(3'd1, v); check("R11 disable address", v, 10'h000);
        for (int a = 5; a < 8; a++) begin
            rd(3'(a), v); check("R11 unmapped", v, 10'h000);
        end
        rd(3'd3, v); check("R11 sticky first read", v, 10'h020);
        @(negedge clk);
        rd(3'd3, v); check("R11 sticky second read", v, 10'h020);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mask_set_clear();
        t_mask_ignored();
        t_live_copy();
        t_events();
        t_set_wins();
        t_live_reassert();
        t_irq();
        t_read_map();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule